// File: doc/BRIEF.md
# Wide Alarm Controller over a 16-bit Compare Timer

This block turns a small 16-bit compare timer into a 32-bit time base with one one-shot alarm. The timer counts up by one each clock; when its count equals the compare value, the next tick returns the count to zero and raises a match flag. The controller keeps a 32-bit base that absorbs every completed timer period. It presents `now` as the base plus the live count, plus one full period while a match is still waiting to be handled, so `now` never stalls or jumps. An alarm is armed with a relative or an absolute command. A wait longer than the timer range is split into compare chunks of at most 0xFFFF. When the 32-bit target is reached the controller issues a one-cycle fire pulse. A cancel drops the pending alarm. After a cancel or a fire, the timer runs in standby at full range.

The controller has two states. STANDBY means no alarm is pending, and ARMED means one is. The transitions are: *arm* (STANDBY or ARMED to ARMED on any set command), *reload* (ARMED to ARMED on a match whose target is still ahead), *fire* (ARMED to STANDBY on a match whose target is reached, or is late by the margin), *cancel* (ARMED to STANDBY on a cancel command) and *fill* (STANDBY to STANDBY on a match, which rewrites the compare register to 0xFFFF).

The timer contract is as follows. A restart strobe zeroes the count, loads the compare value and clears the flag on the next edge. A compare write takes effect on the same edge, including for that edge's match test. A clear strobe drops the flag unless a new match lands on that edge. Offsets must stay below 2^31, because a target counts as ahead when the wrapped difference from the base is positive. All 32-bit sums wrap modulo 2^32.

Top module: `wide_alarm_ctl`

## Requirements
- R1: During reset `now_o` is 0, `alarm_fire` is 0, and no timer strobe is active.
- R2: Once out of reset, `now_o` rises by exactly 1 every clock. This holds across matches, restarts, reloads, standby fills and a set issued while the match flag is high.
- R3: A relative set asserts `tmr_restart` in the same cycle, with `tmr_cmp` equal to the offset clamped to 0xFFFF. The target becomes `now_o` + 1 + offset.
- R4: An absolute set uses the offset `cmd_time` − `now_o`, so the target becomes `cmd_time` + 1. The restart compare value is that offset clamped to 0xFFFF.
- R5: Each armed alarm produces exactly one `alarm_fire` pulse, one cycle wide, in a cycle where `now_o` − target is 1 or 2. This holds for offsets of 0, for small offsets and for offsets above 0xFFFF, which are reached through compare reloads.
- R6: After a cancel, the cancelled alarm never fires. The next match writes 0xFFFF to the compare register.
- R7: Whenever no alarm is pending, every compare write carries 0xFFFF.
- R8: A set command in the cycle where a pending alarm would fire suppresses that fire. Only the new alarm fires.
- R9: In every cycle where the match flag is high and no set is issued, `tmr_clr` is asserted. Any compare rewrite for that match is issued in the same cycle, never later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_set_rel | input | 1 | Arm the alarm `cmd_time` ticks ahead |
| cmd_set_abs | input | 1 | Arm the alarm for absolute time `cmd_time` |
| cmd_cancel | input | 1 | Drop the pending alarm |
| cmd_time | input | 32 | Offset or absolute time for a set |
| now_o | output | 32 | 32-bit running time |
| alarm_fire | output | 1 | One-cycle alarm pulse |
| tmr_count | input | 16 | Live count of the 16-bit timer |
| tmr_match | input | 1 | Timer match flag |
| tmr_cmp | output | 16 | Compare value to load |
| tmr_restart | output | 1 | Zero the count and load `tmr_cmp` |
| tmr_cmp_wr | output | 1 | Write `tmr_cmp` while the timer runs |
| tmr_clr | output | 1 | Clear the match flag |

## Verification
The bench targets the following cases:
- **Offset of exactly 0x10000.** The first chunk lands the base on the target itself. An off-by-one in the period sum would fire a cycle early or wait a whole extra range.
- **Offset of 70000, which needs a reload.** A wrong remainder would fire far outside the two-cycle window.
- **Zero offset.** A period sum that ignored the pending flag would break the step-of-one check on `now_o`.
- **Set issued exactly when the old alarm's final match is flagged.** A design that let the fire win would pulse on a target the bench no longer holds.
- **Cancel before the first match.** The bench expects silence. It also expects the next compare write to carry the full range, which a design that kept reloading the stale distance would violate.

// File: rtl/wat_pkg.sv
package wat_pkg;
    typedef enum logic [0:0] {
        ST_STANDBY,
        ST_ARMED
    } wat_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ARM,
        ACT_RELOAD,
        ACT_FILL,
        ACT_FIRE,
        ACT_CANCEL
    } wat_act_e;
endpackage

// File: rtl/wat_clamp.sv
module wat_clamp #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [OUT_W-1:0] value_o
);
    localparam int HI_W = IN_W - OUT_W;

    generate
        if (HI_W > 0) begin : g_sat
            assign value_o = (|value_i[IN_W-1:OUT_W]) ? {OUT_W{1'b1}} : value_i[OUT_W-1:0];
        end else begin : g_pass
            assign value_o = value_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/wat_decide.sv
module wat_decide #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16,
    parameter int MARGIN = 1
) (
    input  logic [TIME_W-1:0] target_i,
    input  logic [TIME_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [TIME_W-1:0] dist_o,
    output logic              ahead_o,
    output logic              late_o
);
    logic [TIME_W-1:0] guard;

    always_comb begin
        dist_o  = target_i - base_i;
        ahead_o = !dist_o[TIME_W-1] && (dist_o != '0);
        guard   = TIME_W'(count_i) + TIME_W'(MARGIN);
        late_o  = dist_o < guard;
    end
endmodule

// File: rtl/wide_alarm_ctl.sv
module wide_alarm_ctl
    import wat_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16,
    parameter int MARGIN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_set_rel,
    input  logic              cmd_set_abs,
    input  logic              cmd_cancel,
    input  logic [TIME_W-1:0] cmd_time,
    output logic [TIME_W-1:0] now_o,
    output logic              alarm_fire,
    input  logic [CNT_W-1:0]  tmr_count,
    input  logic              tmr_match,
    output logic [CNT_W-1:0]  tmr_cmp,
    output logic              tmr_restart,
    output logic              tmr_cmp_wr,
    output logic              tmr_clr
);
    localparam logic [CNT_W-1:0]  CMP_FULL = {CNT_W{1'b1}};
    localparam logic [TIME_W-1:0] ONE      = TIME_W'(1);

    wat_state_e        state_q, state_d;
    wat_act_e          act;
    logic [TIME_W-1:0] base_q, base_d;
    logic [TIME_W-1:0] target_q, target_d;
    logic [CNT_W-1:0]  cmp_q, cmp_d;
    logic              fire_d;

    logic [TIME_W-1:0] period_w, now_w, match_base, offset_w, dist_w;
    logic [CNT_W-1:0]  off_clamp, dist_clamp;
    logic              set_any, ahead_w, late_w;

    // time view: a flagged but unhandled match already holds one full period
    always_comb begin
        period_w   = TIME_W'(cmp_q) + ONE;
        now_w      = base_q + TIME_W'(tmr_count) + (tmr_match ? period_w : '0);
        match_base = base_q + period_w;
        set_any    = cmd_set_rel | cmd_set_abs;
        offset_w   = cmd_set_abs ? (cmd_time - now_w) : cmd_time;
    end

    wat_clamp #(.IN_W(TIME_W), .OUT_W(CNT_W)) u_off_clamp (
        .value_i (offset_w),
        .value_o (off_clamp)
    );

    wat_decide #(.TIME_W(TIME_W), .CNT_W(CNT_W), .MARGIN(MARGIN)) u_decide (
        .target_i (target_q),
        .base_i   (match_base),
        .count_i  (tmr_count),
        .dist_o   (dist_w),
        .ahead_o  (ahead_w),
        .late_o   (late_w)
    );

    wat_clamp #(.IN_W(TIME_W), .OUT_W(CNT_W)) u_dist_clamp (
        .value_i (dist_w),
        .value_o (dist_clamp)
    );

    // transition selection
    always_comb begin
        act     = ACT_NONE;
        state_d = state_q;
        if (set_any) begin
            act     = ACT_ARM;
            state_d = ST_ARMED;
        end else if (tmr_match) begin
            unique case (state_q)
                ST_ARMED: begin
                    if (cmd_cancel) begin
                        act     = ACT_FILL;
                        state_d = ST_STANDBY;
                    end else if (!ahead_w || late_w) begin
                        act     = ACT_FIRE;
                        state_d = ST_STANDBY;
                    end else begin
                        act     = ACT_RELOAD;
                    end
                end
                ST_STANDBY: act = ACT_FILL;
                default: act = ACT_NONE;
            endcase
        end else if (cmd_cancel) begin
            act     = ACT_CANCEL;
            state_d = ST_STANDBY;
        end
    end

    // outputs and datapath next values
    always_comb begin
        tmr_restart = (act == ACT_ARM);
        tmr_cmp_wr  = (act == ACT_RELOAD) || (act == ACT_FILL);
        tmr_clr     = (act == ACT_ARM) || (act == ACT_RELOAD) ||
                      (act == ACT_FILL) || (act == ACT_FIRE);
        fire_d      = (act == ACT_FIRE);
        unique case (act)
            ACT_ARM:    tmr_cmp = off_clamp;
            ACT_RELOAD: tmr_cmp = dist_clamp;
            ACT_FILL:   tmr_cmp = CMP_FULL;
            default:    tmr_cmp = cmp_q;
        endcase
        cmp_d    = (tmr_restart || tmr_cmp_wr) ? tmr_cmp : cmp_q;
        target_d = tmr_restart ? (now_w + ONE + offset_w) : target_q;
        if (tmr_restart)
            base_d = now_w + ONE;
        else if (tmr_clr)
            base_d = match_base;
        else
            base_d = base_q;
        now_o = now_w;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_STANDBY;
            base_q     <= '0;
            target_q   <= '0;
            cmp_q      <= CMP_FULL;
            alarm_fire <= 1'b0;
        end else begin
            state_q    <= state_d;
            base_q     <= base_d;
            target_q   <= target_d;
            cmp_q      <= cmp_d;
            alarm_fire <= fire_d;
        end
    end
endmodule

// File: rtl/wat_checker.sv
module wat_checker
    import wat_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_set_rel,
    input logic              cmd_set_abs,
    input logic              cmd_cancel,
    input logic [TIME_W-1:0] cmd_time,
    input logic [TIME_W-1:0] now_o,
    input logic              alarm_fire,
    input logic              tmr_match,
    input logic [CNT_W-1:0]  tmr_cmp,
    input logic              tmr_restart,
    input logic              tmr_cmp_wr,
    input logic              tmr_clr,
    input wat_state_e        state_q
);
    logic set_any;
    assign set_any = cmd_set_rel | cmd_set_abs;

    // R2
    now_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (now_o == $past(now_o) + TIME_W'(1)));

    // R3
    rel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set_rel && cmd_time[TIME_W-1:CNT_W] == '0)
        |-> (tmr_restart && tmr_cmp == cmd_time[CNT_W-1:0]));

    // R5
    fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_fire |=> !alarm_fire);

    // R6
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cancel && !set_any) |=> !alarm_fire);

    // R7
    standby_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cmp_wr && state_q == ST_STANDBY) |-> (tmr_cmp == {CNT_W{1'b1}}));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> !alarm_fire);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_match && !set_any) |-> tmr_clr);
endmodule

bind wide_alarm_ctl wat_checker #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_wat_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_set_rel (cmd_set_rel),
    .cmd_set_abs (cmd_set_abs),
    .cmd_cancel  (cmd_cancel),
    .cmd_time    (cmd_time),
    .now_o       (now_o),
    .alarm_fire  (alarm_fire),
    .tmr_match   (tmr_match),
    .tmr_cmp     (tmr_cmp),
    .tmr_restart (tmr_restart),
    .tmr_cmp_wr  (tmr_cmp_wr),
    .tmr_clr     (tmr_clr),
    .state_q     (state_q)
);

// File: tb/tb_wide_alarm_ctl.sv
`timescale 1ns/1ps
module tb_wide_alarm_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_set_rel = 1'b0, cmd_set_abs = 1'b0, cmd_cancel = 1'b0;
    logic [31:0] cmd_time = '0;
    logic [31:0] now_o;
    logic        alarm_fire;
    logic [15:0] tcnt, tcmp, tce, tmr_cmp;
    logic        tflag, tmr_restart, tmr_cmp_wr, tmr_clr;

    int          n_cmp = 0, n_bad = 0;
    logic [31:0] exp_now = '0, tgt_m = '0;
    bit          armed_m = 0, saw_fill = 0;

    always #2.5 clk = ~clk;

    wide_alarm_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_set_rel(cmd_set_rel), .cmd_set_abs(cmd_set_abs), .cmd_cancel(cmd_cancel),
        .cmd_time(cmd_time), .now_o(now_o), .alarm_fire(alarm_fire),
        .tmr_count(tcnt), .tmr_match(tflag), .tmr_cmp(tmr_cmp),
        .tmr_restart(tmr_restart), .tmr_cmp_wr(tmr_cmp_wr), .tmr_clr(tmr_clr)
    );

    // behavioural 16-bit compare timer
    assign tce = tmr_cmp_wr ? tmr_cmp : tcmp;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0; tcmp <= 16'hFFFF; tflag <= 1'b0;
        end else if (tmr_restart) begin
            tcnt <= '0; tcmp <= tmr_cmp; tflag <= 1'b0;
        end else begin
            if (tmr_cmp_wr) tcmp <= tmr_cmp;
            if (tcnt == tce) begin
                tcnt <= '0; tflag <= 1'b1;
            end else begin
                tcnt <= tcnt + 16'd1;
                if (tmr_clr) tflag <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit rel, input bit abs, input bit cxl, input logic [31:0] t);
        logic [31:0] cur, d, off;
        logic [15:0] cl;
        @(negedge clk);
        cur = exp_now;
        chk(now_o == cur, "R2 now step", now_o, cur);
        exp_now = cur + 32'd1;
        d = now_o - tgt_m;
        if (alarm_fire) begin
            chk(armed_m && (d == 32'd1 || d == 32'd2), "R5/R8 fire window", d, 32'd1);
            armed_m = 0;
        end else if (armed_m && d == 32'd3) begin
            chk(1'b0, "R5 missed fire", d, 32'd2);
            armed_m = 0;
        end
        cmd_set_rel = rel; cmd_set_abs = abs; cmd_cancel = cxl; cmd_time = t;
        if (rel) begin tgt_m = cur + 32'd1 + t; armed_m = 1; end
        else if (abs) begin tgt_m = t + 32'd1; armed_m = 1; end
        else if (cxl) armed_m = 0;
        #1;
        if (rel || abs) begin
            off = rel ? t : (t - cur);
            cl  = (off > 32'hFFFF) ? 16'hFFFF : off[15:0];
            chk(tmr_restart && tmr_cmp == cl, "R3/R4 restart compare", {15'd0, tmr_restart, tmr_cmp}, {15'd1, 1'b1, cl});
        end
        if (tmr_cmp_wr && !armed_m) begin
            chk(tmr_cmp == 16'hFFFF, "R6/R7 standby fill", tmr_cmp, 32'hFFFF);
            saw_fill = 1;
        end
        if (tflag && !(rel || abs))
            chk(tmr_clr, "R9 flag clear", tmr_clr, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit hit;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(now_o == 0, "R1 reset now", now_o, 0);
        chk(!alarm_fire, "R1 reset fire", alarm_fire, 0);
        chk(!tmr_restart && !tmr_cmp_wr, "R1 reset strobes", {tmr_restart, tmr_cmp_wr}, 0);
        rst_n = 1'b1;
        exp_now = 32'd1;

        idle(20);                               // R2 free running
        step(1, 0, 0, 32'd5);  idle(20);        // R5 small offset
        chk(!armed_m, "R5 fired small", armed_m, 0);
        step(1, 0, 0, 32'd0);  idle(10);        // R5 zero offset
        chk(!armed_m, "R5 fired zero", armed_m, 0);
        step(1, 0, 0, 32'd70000); idle(70010);  // R5 chunked with reload
        chk(!armed_m, "R5 fired long", armed_m, 0);
        step(1, 0, 0, 32'h10000); idle(65540);  // R5 exact range boundary
        chk(!armed_m, "R5 fired boundary", armed_m, 0);
        step(0, 1, 0, exp_now + 32'd40); idle(50); // R4 absolute
        chk(!armed_m, "R4 fired absolute", armed_m, 0);

        // R6 cancel, then standby fill at next match
        saw_fill = 0;
        step(1, 0, 0, 32'd100); idle(20);
        step(0, 0, 1, 32'd0);   idle(300);
        chk(saw_fill, "R6 fill after cancel", saw_fill, 1);

        // R8 set colliding with the final match of a pending alarm
        step(1, 0, 0, 32'd10);
        hit = 0;
        for (int i = 0; i < 40 && !hit; i++) begin
            @(posedge clk); #1;
            if (tflag) begin step(1, 0, 0, 32'd30); hit = 1; end
            else step(0, 0, 0, 0);
        end
        chk(hit, "R8 collision reached", hit, 1);
        idle(50);
        chk(!armed_m, "R8 new alarm fired", armed_m, 0);

        // R3 clamp of a large relative offset, then cancel
        step(1, 0, 0, 32'd200000);
        step(0, 0, 1, 32'd0);
        idle(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule